// File: doc/BRIEF.md
# Host-to-Device DDR Command and Width Bridge

This block lets a 16-bit double-data-rate host controller, which expects an older memory with a CAS latency of 3, drive an 8-bit DDR3 device instead. The block runs on the memory clock, which is exactly four times the host clock. A free-running phase counter splits each host clock into four memory-clock slots, and the first memory cycle after reset is slot 0. Host command, bank and address are held for a whole host cycle and sampled once, at the end of slot 0. An accepted command then appears on the device command lines for one memory cycle, during slot 2.

Each host data word is split into two device beats, and on reads the beats are put back together in the same order. The memory side has twice the host bandwidth. That margin returns read data through short shift pipelines with no buffer memory: the device is run with a read latency of 8 and a write latency of 6 memory clocks, and the data still reaches the host three host clocks after the read.

The two host bank bits select device banks 0 to 3, so the upper four device banks are never used. Before forwarding a command, a timing guard for each bank checks the activate-to-access, activate-to-precharge and precharge-to-activate minimums. A command that would break one of them is dropped. Nothing is forwarded until the initialization-done input is high.

Top module: `ddr_width_bridge`

## Requirements
- R1: While reset is high and on the cycle after it, `dev_cmd` is 0 (no operation), `dev_wen` is 0 and `host_rvalid` is 0.
- R2: A command accepted in host cycle k is on `dev_cmd` only during memory cycle 4k+2. It stays there for exactly one memory cycle, and `dev_addr` equals the sampled host address.
- R3: For an accepted command, `dev_bank` is the host bank zero-extended to 3 bits, so bit 2 is always 0.
- R4: Command codes are the same on both sides: 0 no operation, 1 activate, 2 read, 3 write, 4 precharge. Host codes 5 to 7 act as no operation.
- R5: The write data for a write accepted in host cycle k is taken from `host_wdata` in host cycle k+1. `dev_wdq` carries `host_wdata[15:0]` in memory cycle 4k+8 and `host_wdata[31:16]` in memory cycle 4k+9. Bits [7:0] of each are the first beat, and `dev_wen` is high in exactly those cycles.
- R6: For a read accepted in host cycle k, the block samples `dev_rdq` in memory cycles 4k+10 and 4k+11. It presents {second, first} on `host_rdata` with `host_rvalid` high for memory cycles 4k+12 to 4k+15, which is host cycle k+3.
- R7: Reads accepted in consecutive host cycles give `host_rvalid` high continuously, with each host cycle carrying its own read's data.
- R8: A read or write to a bank that is closed, or that was activated fewer than 8 memory cycles earlier, is dropped.
- R9: A precharge to an open bank fewer than 20 memory cycles after its activate is dropped. A precharge to a closed bank is forwarded and changes nothing.
- R10: An activate to an open bank, or fewer than 8 memory cycles after that bank's precharge, is dropped.
- R11: While `init_done` is low during a host cycle, that cycle's command is dropped and leaves no bank state behind.
- R12: A dropped read or write produces no `dev_wen` and no `host_rvalid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock, four times the host clock |
| rst | input | 1 | Synchronous active-high reset |
| init_done | input | 1 | Device initialization finished; gates all commands |
| host_cmd | input | 3 | Host command code |
| host_bank | input | 2 | Host bank select |
| host_addr | input | 14 | Host row or column address |
| host_wdata | input | 32 | Host write data for one host cycle: two 16-bit words, low word first |
| host_rdata | output | 32 | Read data returned to the host, low word first |
| host_rvalid | output | 1 | Read data valid for one host cycle |
| dev_cmd | output | 3 | Device command code |
| dev_bank | output | 3 | Device bank select |
| dev_addr | output | 14 | Device address |
| dev_wdq | output | 16 | Two device write beats per memory clock, [7:0] first |
| dev_wen | output | 1 | Device write beats valid |
| dev_rdq | input | 16 | Two device read beats per memory clock, [7:0] first |

## Verification
The bench targets timing-window edges. Accesses at exactly 4 and 8 memory cycles after an activate catch an off-by-one guard, which would either forward a too-early access or drop a legal one. Precharge at 8 and 20 cycles and re-activate at 4 and 8 cycles do the same for the other two windows. Back-to-back writes and reads check that a wrongly sized pipeline does not overwrite a held write word or leave a gap or shifted word in the returned read stream. A device read pattern that changes every cycle exposes swapped beats or a read latency off by one. A long stretch of mixed random commands, with init held low at the start, checks that gated and dropped commands leave no trace.

// File: rtl/ddrb_pkg.sv
package ddrb_pkg;
    localparam int RATIO      = 4;
    localparam int PH_W       = $clog2(RATIO);
    localparam int HBANK_W    = 2;
    localparam int DBANK_W    = 3;
    localparam int ADDR_W     = 14;
    localparam int DBEAT_W    = 8;
    localparam int DBUS_W     = 2 * DBEAT_W;
    localparam int HBUS_W     = 2 * DBUS_W;
    localparam int NUM_BANKS  = 1 << HBANK_W;
    localparam int CL_DEV     = 8;
    localparam int CWL_DEV    = 6;
    localparam int HOST_CL    = 3;
    localparam int ISSUE_SLOT = 1;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4
    } cmd_t;

    typedef struct packed {
        cmd_t               cmd;
        logic [HBANK_W-1:0] bank;
        logic [ADDR_W-1:0]  addr;
    } host_req_t;

    function automatic cmd_t decode_cmd(input logic [2:0] code);
        case (code)
            3'd1:    return CMD_ACT;
            3'd2:    return CMD_RD;
            3'd3:    return CMD_WR;
            3'd4:    return CMD_PRE;
            default: return CMD_NOP;
        endcase
    endfunction

    function automatic logic [DBANK_W-1:0] to_dev_bank(input logic [HBANK_W-1:0] b);
        return {{(DBANK_W-HBANK_W){1'b0}}, b};
    endfunction

    function automatic int max3(input int a, input int b, input int c);
        int m;
        m = (a > b) ? a : b;
        return (m > c) ? m : c;
    endfunction
endpackage

// File: rtl/bank_timing_guard.sv
module bank_timing_guard import ddrb_pkg::*; #(
    parameter int T_RCD = 8,
    parameter int T_RAS = 20,
    parameter int T_RP  = 8,
    parameter int CNT_W = 5
) (
    input  logic clk,
    input  logic rst,
    input  logic sel,
    input  logic issue,
    input  cmd_t cmd,
    output logic allow
);
    localparam logic [CNT_W-1:0] SAT = CNT_W'(max3(T_RCD, T_RAS, T_RP));

    logic             open_q;
    logic [CNT_W-1:0] since_q;
    logic             restart;

    always_comb begin
        case (cmd)
            CMD_ACT: allow = !open_q && (since_q >= CNT_W'(T_RP));
            CMD_RD,
            CMD_WR:  allow = open_q && (since_q >= CNT_W'(T_RCD));
            CMD_PRE: allow = !open_q || (since_q >= CNT_W'(T_RAS));
            default: allow = 1'b0;
        endcase
    end

    assign restart = issue && sel && allow &&
                     ((cmd == CMD_ACT) || (cmd == CMD_PRE && open_q));

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q  <= 1'b0;
            since_q <= SAT;
        end else if (restart) begin
            open_q  <= (cmd == CMD_ACT);
            since_q <= CNT_W'(1);
        end else if (since_q != SAT) begin
            since_q <= since_q + 1'b1;
        end
    end

    AST_RESTART_FROM_SAFE: assert property (@(posedge clk) disable iff (rst)
        restart |=> (since_q == CNT_W'(1))); // R10
endmodule

// File: rtl/wr_beat_path.sv
module wr_beat_path import ddrb_pkg::*; #(
    parameter int CWL = CWL_DEV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              slot0,
    input  logic              start,
    input  logic [HBUS_W-1:0] host_wdata,
    output logic [DBUS_W-1:0] dev_wdq,
    output logic              dev_wen
);
    logic [CWL:0]        pend_q;
    logic [HBUS_W-1:0]   wbuf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q  <= '0;
            wbuf_q  <= '0;
            dev_wdq <= '0;
            dev_wen <= 1'b0;
        end else begin
            pend_q <= {pend_q[CWL-1:0], start};
            if (slot0) wbuf_q <= host_wdata;
            if (pend_q[CWL-1]) begin
                dev_wdq <= wbuf_q[DBUS_W-1:0];
                dev_wen <= 1'b1;
            end else if (pend_q[CWL]) begin
                dev_wdq <= wbuf_q[HBUS_W-1:DBUS_W];
                dev_wen <= 1'b1;
            end else begin
                dev_wen <= 1'b0;
            end
        end
    end

    AST_WEN_PAIRED: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_wen) |=> dev_wen); // R5
    AST_WEN_NO_TRIPLE: assert property (@(posedge clk) disable iff (rst)
        (dev_wen && $past(dev_wen)) |=> !dev_wen); // R5
endmodule

// File: rtl/rd_beat_path.sv
module rd_beat_path import ddrb_pkg::*; #(
    parameter int CL = CL_DEV
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              last_slot,
    input  logic              start,
    input  logic [DBUS_W-1:0] dev_rdq,
    output logic [HBUS_W-1:0] host_rdata,
    output logic              host_rvalid
);
    logic [CL+1:0]       pend_q;
    logic [DBUS_W-1:0]   first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pend_q      <= '0;
            first_q     <= '0;
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            pend_q <= {pend_q[CL:0], start};
            if (pend_q[CL]) first_q <= dev_rdq;
            if (pend_q[CL+1]) begin
                host_rdata  <= {dev_rdq, first_q};
                host_rvalid <= 1'b1;
            end else if (last_slot) begin
                host_rvalid <= 1'b0;
            end
        end
    end

    AST_RVALID_HELD: assert property (@(posedge clk) disable iff (rst)
        $rose(host_rvalid) |=> host_rvalid); // R7
    AST_RVALID_ONLY_AT_SLOT0: assert property (@(posedge clk) disable iff (rst)
        $rose(host_rvalid) |-> $past(last_slot)); // R6
endmodule

// File: rtl/ddr_width_bridge.sv
module ddr_width_bridge import ddrb_pkg::*; #(
    parameter int T_RCD_CK = 8,
    parameter int T_RAS_CK = 20,
    parameter int T_RP_CK  = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               init_done,
    input  logic [2:0]         host_cmd,
    input  logic [HBANK_W-1:0] host_bank,
    input  logic [ADDR_W-1:0]  host_addr,
    input  logic [HBUS_W-1:0]  host_wdata,
    output logic [HBUS_W-1:0]  host_rdata,
    output logic               host_rvalid,
    output logic [2:0]         dev_cmd,
    output logic [DBANK_W-1:0] dev_bank,
    output logic [ADDR_W-1:0]  dev_addr,
    output logic [DBUS_W-1:0]  dev_wdq,
    output logic               dev_wen,
    input  logic [DBUS_W-1:0]  dev_rdq
);
    localparam int T_SAT = max3(T_RCD_CK, T_RAS_CK, T_RP_CK);
    localparam int CNT_W = $clog2(T_SAT + 1);

    logic [PH_W-1:0]      ph_q;
    host_req_t            req_q;
    logic                 init_q;
    logic [NUM_BANKS-1:0] bank_ok;
    logic                 issue_edge;
    logic                 fire;
    cmd_t                 dev_cmd_q;

    always_ff @(posedge clk) begin
        if (rst)                            ph_q <= '0;
        else if (ph_q == PH_W'(RATIO - 1))  ph_q <= '0;
        else                                ph_q <= ph_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            req_q  <= '{cmd: CMD_NOP, bank: '0, addr: '0};
            init_q <= 1'b0;
        end else if (ph_q == '0) begin
            req_q  <= '{cmd: decode_cmd(host_cmd), bank: host_bank, addr: host_addr};
            init_q <= init_done;
        end
    end

    assign issue_edge = (ph_q == PH_W'(ISSUE_SLOT));
    assign fire = issue_edge && init_q && (req_q.cmd != CMD_NOP) && bank_ok[req_q.bank];

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_guard
        bank_timing_guard #(
            .T_RCD(T_RCD_CK), .T_RAS(T_RAS_CK), .T_RP(T_RP_CK), .CNT_W(CNT_W)
        ) u_guard (
            .clk   (clk),
            .rst   (rst),
            .sel   (req_q.bank == HBANK_W'(g)),
            .issue (issue_edge && init_q),
            .cmd   (req_q.cmd),
            .allow (bank_ok[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            dev_cmd_q <= CMD_NOP;
            dev_bank  <= '0;
            dev_addr  <= '0;
        end else if (fire) begin
            dev_cmd_q <= req_q.cmd;
            dev_bank  <= to_dev_bank(req_q.bank);
            dev_addr  <= req_q.addr;
        end else begin
            dev_cmd_q <= CMD_NOP;
        end
    end

    assign dev_cmd = dev_cmd_q;

    wr_beat_path #(.CWL(CWL_DEV)) u_wr (
        .clk        (clk),
        .rst        (rst),
        .slot0      (ph_q == '0),
        .start      (fire && req_q.cmd == CMD_WR),
        .host_wdata (host_wdata),
        .dev_wdq    (dev_wdq),
        .dev_wen    (dev_wen)
    );

    rd_beat_path #(.CL(CL_DEV)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .last_slot   (ph_q == PH_W'(RATIO - 1)),
        .start       (fire && req_q.cmd == CMD_RD),
        .dev_rdq     (dev_rdq),
        .host_rdata  (host_rdata),
        .host_rvalid (host_rvalid)
    );

    AST_CMD_IN_FIXED_SLOT: assert property (@(posedge clk) disable iff (rst)
        (dev_cmd != 3'd0) |-> (ph_q == PH_W'(ISSUE_SLOT + 1))); // R2
    AST_CMD_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
        (dev_cmd != 3'd0) |=> (dev_cmd == 3'd0)); // R2
    AST_UPPER_BANKS_IDLE: assert property (@(posedge clk) disable iff (rst)
        (dev_cmd != 3'd0) |-> !dev_bank[DBANK_W-1]); // R3
    AST_NO_CMD_BEFORE_INIT: assert property (@(posedge clk) disable iff (rst)
        !$past(init_done) |-> (dev_cmd == 3'd0)); // R11
    AST_WR_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(dev_wen) |-> ($past(dev_cmd, CWL_DEV) == 3'd3)); // R5
    AST_RD_LATENCY: assert property (@(posedge clk) disable iff (rst)
        $rose(host_rvalid) |-> ($past(dev_cmd, HOST_CL*RATIO - ISSUE_SLOT - 1) == 3'd2)); // R6
endmodule

// File: tb/test_ddr_width_bridge.sv
module test_ddr_width_bridge;
    localparam int NH = 120;
    localparam int NC = 4 * NH + 20;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        init_done = 1'b0;
    logic [2:0]  host_cmd = '0;
    logic [1:0]  host_bank = '0;
    logic [13:0] host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_rvalid;
    logic [2:0]  dev_cmd;
    logic [2:0]  dev_bank;
    logic [13:0] dev_addr;
    logic [15:0] dev_wdq;
    logic        dev_wen;
    logic [15:0] dev_rdq = '0;

    always #2.5 clk = ~clk;

    ddr_width_bridge i_ddr_width_bridge (
        .clk(clk), .rst(rst), .init_done(init_done),
        .host_cmd(host_cmd), .host_bank(host_bank), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .host_rvalid(host_rvalid),
        .dev_cmd(dev_cmd), .dev_bank(dev_bank), .dev_addr(dev_addr),
        .dev_wdq(dev_wdq), .dev_wen(dev_wen), .dev_rdq(dev_rdq)
    );

    // host program, one entry per host cycle
    logic [2:0]  h_cmd  [0:NH];
    logic [1:0]  h_bank [0:NH];
    logic [13:0] h_addr [0:NH];
    logic [31:0] h_wd   [0:NH];
    logic        h_init [0:NH];

    // expected values, one entry per memory cycle
    logic [2:0]  e_cmd  [0:NC+16];
    logic [2:0]  e_bank [0:NC+16];
    logic [13:0] e_addr [0:NC+16];
    logic        e_wen  [0:NC+16];
    logic [15:0] e_wdq  [0:NC+16];
    logic        e_rv   [0:NC+16];
    logic [31:0] e_rd   [0:NC+16];
    string       e_tag  [0:NC+16];

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    function automatic logic [15:0] pat(input int n);
        return 16'(n * 40503 + 4660) ^ 16'(n << 9);
    endfunction

    task automatic put(input int k, input int c, input int b, input int a, input logic [31:0] wd);
        h_cmd[k]  = 3'(c);
        h_bank[k] = 2'(b);
        h_addr[k] = 14'(a);
        h_wd[k]   = wd;
    endtask

    task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
        end
    endtask

    // behavioural reference: bank state in host cycles, timing in memory clocks
    task automatic build_model();
        bit open [0:3];
        int last [0:3];
        for (int b = 0; b < 4; b++) begin open[b] = 0; last[b] = -100; end
        for (int i = 0; i <= NC + 16; i++) begin
            e_cmd[i] = 0; e_bank[i] = 0; e_addr[i] = 0; e_wen[i] = 0;
            e_wdq[i] = 0; e_rv[i] = 0; e_rd[i] = 0; e_tag[i] = "R2";
        end
        for (int k = 0; k < NH; k++) begin
            int c;
            int b;
            int gap;
            bit ok;
            c   = int'(h_cmd[k]);
            b   = int'(h_bank[k]);
            gap = 4 * (k - last[b]);
            ok  = 0;
            if (c >= 1 && c <= 4) begin
                if (!h_init[k]) begin
                    e_tag[4*k+2] = "R11";
                end else begin
                    case (c)
                        1: begin ok = !open[b] && gap >= 8;  if (!ok) e_tag[4*k+2] = "R10"; end
                        2, 3: begin ok = open[b] && gap >= 8; if (!ok) e_tag[4*k+2] = "R8"; end
                        default: begin ok = !open[b] || gap >= 20; if (!ok) e_tag[4*k+2] = "R9"; end
                    endcase
                end
            end else if (c != 0) begin
                e_tag[4*k+2] = "R4";
            end
            if (ok) begin
                e_cmd[4*k+2]  = 3'(c);
                e_bank[4*k+2] = {1'b0, h_bank[k]};
                e_addr[4*k+2] = h_addr[k];
                e_tag[4*k+2]  = "R4";
                if (c == 1) begin open[b] = 1; last[b] = k; end
                if (c == 4 && open[b]) begin open[b] = 0; last[b] = k; end
                if (c == 3) begin
                    e_wen[4*k+8] = 1; e_wdq[4*k+8] = h_wd[k+1][15:0];
                    e_wen[4*k+9] = 1; e_wdq[4*k+9] = h_wd[k+1][31:16];
                end
                if (c == 2) begin
                    for (int j = 12; j < 16; j++) begin
                        e_rv[4*k+j] = 1;
                        e_rd[4*k+j] = {pat(4*k+11), pat(4*k+10)};
                    end
                end
            end
        end
    endtask

    initial begin
        for (int k = 0; k <= NH; k++) begin
            put(k, 0, 0, 0, 32'($urandom));
            h_init[k] = (k >= 3);
        end
        put(1, 1, 0, 14'h0111, 32'h0);        // R11: gated activate
        put(2, 3, 0, 14'h0222, 32'h0);        // R11: gated write
        put(4, 1, 0, 14'h1234, 32'h0);        // activate bank 0
        put(5, 2, 0, 14'h0008, 32'h0);        // R8: read only 4 clocks after activate
        put(6, 3, 0, 14'h0010, 32'h0);        // R8 boundary: 8 clocks, accepted
        put(7, 3, 0, 14'h0020, 32'hA1B2C3D4); // R5: back-to-back write
        put(8, 2, 0, 14'h0030, 32'h5E6F7081); // R6
        put(9, 2, 0, 14'h0040, 32'h0);        // R7: back-to-back read
        put(10, 2, 1, 14'h0050, 32'h0);       // R8/R12: read on closed bank
        put(11, 4, 0, 14'h0000, 32'h0);       // precharge bank 0
        put(12, 1, 2, 14'h2AAA, 32'h0);
        put(13, 3, 0, 14'h0060, 32'h0);       // R12: write to closed bank
        put(14, 4, 2, 14'h0000, 32'h0);       // R9: 8 clocks, too early
        put(16, 4, 2, 14'h0000, 32'h0);       // R9: 16 clocks, too early
        put(17, 4, 2, 14'h0000, 32'h0);       // R9 boundary: 20 clocks, accepted
        put(18, 1, 2, 14'h0001, 32'h0);       // R10: 4 clocks after precharge
        put(19, 1, 2, 14'h0002, 32'h0);       // R10 boundary: 8 clocks
        put(20, 1, 2, 14'h0003, 32'h0);       // R10: bank already open
        put(21, 6, 1, 14'h0004, 32'h0);       // R4: undefined code
        put(22, 1, 3, 14'h3FFF, 32'h0);       // R3: top host bank
        put(24, 2, 3, 14'h0070, 32'h0);
        put(25, 3, 3, 14'h0080, 32'hDEADBEEF);
        put(26, 2, 3, 14'h0090, 32'h13572468);
        put(27, 4, 1, 14'h0000, 32'h0);       // R9: precharge on closed bank
        for (int k = 30; k < NH - 6; k++)
            put(k, int'($urandom_range(0, 5)), int'($urandom_range(0, 3)), int'($urandom_range(0, 16383)), 32'($urandom));
        build_model();

        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", "dev_cmd in reset", 32'(dev_cmd), 32'd0);
        chk("R1", "dev_wen in reset", 32'(dev_wen), 32'd0);
        chk("R1", "host_rvalid in reset", 32'(host_rvalid), 32'd0);
        @(posedge clk);
        #1 rst = 1'b0;
        for (int n = 0; n < NC; n++) begin
            int k;
            k = (n / 4 < NH) ? n / 4 : NH;
            host_cmd   = h_cmd[k];
            host_bank  = h_bank[k];
            host_addr  = h_addr[k];
            host_wdata = h_wd[k];
            init_done  = h_init[k];
            dev_rdq    = pat(n);
            @(negedge clk);
            chk(e_tag[n], "dev_cmd", 32'(dev_cmd), 32'(e_cmd[n]));
            if (e_cmd[n] != 0) begin
                chk("R3", "dev_bank", 32'(dev_bank), 32'(e_bank[n]));
                chk("R2", "dev_addr", 32'(dev_addr), 32'(e_addr[n]));
            end
            chk((n < 2) ? "R1" : "R12", "dev_wen", 32'(dev_wen), 32'(e_wen[n]));
            if (e_wen[n]) chk("R5", "dev_wdq", 32'(dev_wdq), 32'(e_wdq[n]));
            chk((n < 2) ? "R1" : "R7", "host_rvalid", 32'(host_rvalid), 32'(e_rv[n]));
            if (e_rv[n]) chk("R6", "host_rdata", host_rdata, e_rd[n]);
            @(posedge clk);
            #1;
        end
        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule